// File: doc/BRIEF.md
# Receive-Level RTS Flow Controller

This block drives an active-low request-to-send pin from the fill level of a receive queue. When the queue gets full enough, the pin is released (driven high) so the far-end sender pauses. Once the queue has drained well below that point, the pin is driven low again and the sender can resume. The pause and resume thresholds differ, which gives the pin hysteresis around the receive trigger level. The block also reports when the level has reached the selected trigger, and it raises a one-cycle interrupt request each time the pin goes from low to high.

The queue depth is a parameter (default 32). A 2-bit selector picks one of four rows from a fixed threshold table. Every row is derived from the depth. Automatic control runs only when the automatic-mode enable is set and software has asserted RTS. In every other case the pin is the inverse of the software RTS bit. All outputs are registered, so each one reflects the inputs sampled on the previous rising clock edge. The queue keeps accepting characters after the pin is released, so the block needs no back-pressure path of its own.

Top module: `rx_rts_flow`

## Requirements
- R1: While reset is asserted, and after it is released with no other stimulus, `rts_n` is 1 and both `trig_hit` and `rts_irq` are 0.
- R2: When `auto_rts_en` is 0, `rts_n` equals the inverse of `sw_rts` one clock later, whatever the level.
- R3: `trig_hit` is 1 one clock after `rx_level` is at or above the trigger for `trig_sel`. The triggers are 00→8, 01→16, 10→24 and 11→28.
- R4: In automatic mode (`auto_rts_en`=1 and `sw_rts`=1), a level at or above the pause threshold drives `rts_n` to 1 one clock later. The pause thresholds are 00→16, 01→24, 10→28 and 11→28.
- R5: In automatic mode, a level at or below the resume threshold drives `rts_n` to 0 one clock later. The resume thresholds are 00→0, 01→8, 10→16 and 11→24.
- R6: In automatic mode, a level strictly between the resume and pause thresholds leaves `rts_n` unchanged.
- R7: With `auto_rts_en`=1 but `sw_rts`=0, `rts_n` is 1 one clock later, regardless of the level.
- R8: When `rts_irq_en` is 1, `rts_irq` is 1 for exactly the one cycle in which `rts_n` first reads 1 after reading 0. It is 0 in every other cycle.
- R9: When `rts_irq_en` is 0, a rise of `rts_n` produces no `rts_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 6 | Receive queue fill level, 0 to DEPTH |
| trig_sel | input | 2 | Threshold row select |
| auto_rts_en | input | 1 | Automatic RTS mode enable |
| sw_rts | input | 1 | Software RTS bit, 1 = assert (pin low) |
| rts_irq_en | input | 1 | Enables the RTS rise interrupt |
| rts_n | output | 1 | Request-to-send pin, active low |
| trig_hit | output | 1 | Level has reached the trigger |
| rts_irq | output | 1 | One-cycle interrupt request on a rise of `rts_n` |

## Verification
The embedded properties check the following on every cycle:
- the pause, resume and hold rules of the hysteresis register against whatever thresholds the decoder supplies;
- the manual pass-through of the software bit;
- the forced release when software has not asserted RTS;
- that an interrupt only ever accompanies a fresh rise of the pin and stays quiet when it is disabled.

Only the bench scenarios can show that each selector row decodes to the intended numbers. They also show that the band between the thresholds holds the pin through full downward and upward sweeps, and that every row pauses, resumes and raises its interrupt at the right levels.

// File: rtl/rx_rts_flow_pkg.sv
package rx_rts_flow_pkg;

  // Trigger level for a table row, derived from the queue depth.
  function automatic int unsigned trig_of(int unsigned depth, int unsigned row);
    case (row)
      0:       return depth / 4;
      1:       return depth / 2;
      2:       return (3 * depth) / 4;
      default: return (7 * depth) / 8;
    endcase
  endfunction

  // Pause threshold: the next row's trigger (the top row saturates).
  function automatic int unsigned pause_of(int unsigned depth, int unsigned row);
    return (row < 3) ? trig_of(depth, row + 1) : trig_of(depth, 3);
  endfunction

  // Resume threshold: the previous row's trigger (the bottom row resumes at empty).
  function automatic int unsigned resume_of(int unsigned depth, int unsigned row);
    return (row == 0) ? 0 : trig_of(depth, row - 1);
  endfunction

endpackage

// File: rtl/rx_rts_thresh.sv
module rx_rts_thresh
  import rx_rts_flow_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [LVL_W-1:0] trig_lvl,
  output logic [LVL_W-1:0] pause_lvl,
  output logic [LVL_W-1:0] resume_lvl
);
  localparam int unsigned ROWS = 4;

  logic [LVL_W-1:0] trig_tab   [ROWS];
  logic [LVL_W-1:0] pause_tab  [ROWS];
  logic [LVL_W-1:0] resume_tab [ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign trig_tab[i]   = LVL_W'(trig_of(DEPTH, i));
    assign pause_tab[i]  = LVL_W'(pause_of(DEPTH, i));
    assign resume_tab[i] = LVL_W'(resume_of(DEPTH, i));
  end

  assign trig_lvl   = trig_tab[sel];
  assign pause_lvl  = pause_tab[sel];
  assign resume_lvl = resume_tab[sel];
endmodule

// File: rtl/rx_rts_hyst.sv
module rx_rts_hyst #(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] pause_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             rts_n_nxt,
  output logic             rts_n_q
);
  logic auto_act;
  logic paused_q, paused_d;
  logic act_q;

  assign auto_act = auto_en & sw_rts;

  always_comb begin
    if (!auto_act)      paused_d = 1'b0;
    else if (!paused_q) paused_d = (level >= pause_lvl);
    else                paused_d = (level > resume_lvl);
  end

  assign rts_n_nxt = ~sw_rts | paused_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      rts_n_q  <= 1'b1;
      act_q    <= 1'b0;
    end else begin
      paused_q <= paused_d;
      rts_n_q  <= rts_n_nxt;
      act_q    <= auto_act;
    end
  end

  // R4: reaching the pause threshold releases the pin
  p_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && level >= pause_lvl) |=> rts_n_q);

  // R5: draining to the resume threshold re-asserts the pin
  p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && level <= resume_lvl) |=> !rts_n_q);

  // R6: inside the band the pin holds
  p_band_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && auto_act && level > resume_lvl && level < pause_lvl)
      |=> (rts_n_q == $past(rts_n_q)));

  // R2: manual mode follows the software bit
  p_manual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n_q == !$past(sw_rts)));

  // R7: without the software assert the pin is released
  p_need_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rts |=> rts_n_q);
endmodule

// File: rtl/rx_rts_irq.sv
module rx_rts_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic rts_n_nxt,
  input  logic rts_n_q,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_en & rts_n_nxt & ~rts_n_q;
  end

  // R8: a request only accompanies a fresh rise of the pin
  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (rts_n_q && !$past(rts_n_q)));

  // R9: disabled interrupt stays quiet
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q);
endmodule

// File: rtl/rx_rts_flow.sv
module rx_rts_flow #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       trig_sel,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic             rts_irq_en,
  output logic             rts_n,
  output logic             trig_hit,
  output logic             rts_irq
);
  logic [LVL_W-1:0] trig_lvl, pause_lvl, resume_lvl;
  logic             rts_n_nxt;
  logic             hit_q;

  rx_rts_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_thresh (
    .sel        (trig_sel),
    .trig_lvl   (trig_lvl),
    .pause_lvl  (pause_lvl),
    .resume_lvl (resume_lvl)
  );

  rx_rts_hyst #(.LVL_W(LVL_W)) u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_rts_en),
    .sw_rts     (sw_rts),
    .level      (rx_level),
    .pause_lvl  (pause_lvl),
    .resume_lvl (resume_lvl),
    .rts_n_nxt  (rts_n_nxt),
    .rts_n_q    (rts_n)
  );

  rx_rts_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (rts_irq_en),
    .rts_n_nxt (rts_n_nxt),
    .rts_n_q   (rts_n),
    .irq_q     (rts_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= (rx_level >= trig_lvl);
  end
  assign trig_hit = hit_q;

  // R3: the trigger flag never precedes the trigger level
  p_hit_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < trig_lvl) |=> !trig_hit);
endmodule

// File: tb/rx_rts_flow_tb.sv
module rx_rts_flow_tb;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [1:0] sel;
    logic       aen;
    logic       sw;
    logic       ien;
    logic [5:0] lvl;
    logic       e_rts;
    logic       e_hit;
    logic       e_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd1,1'b0,1'b0,1'b1,6'd0 ,1'b1,1'b0,1'b0,4'd2}, // R2 sw off
    '{2'd1,1'b0,1'b1,1'b1,6'd0 ,1'b0,1'b0,1'b0,4'd2}, // R2 sw on
    '{2'd1,1'b1,1'b1,1'b1,6'd10,1'b0,1'b0,1'b0,4'd6}, // R6
    '{2'd1,1'b1,1'b1,1'b1,6'd16,1'b0,1'b1,1'b0,4'd3}, // R3 trig 16
    '{2'd1,1'b1,1'b1,1'b1,6'd23,1'b0,1'b1,1'b0,4'd6}, // R6
    '{2'd1,1'b1,1'b1,1'b1,6'd24,1'b1,1'b1,1'b1,4'd4}, // R4 pause 24, R8
    '{2'd1,1'b1,1'b1,1'b1,6'd24,1'b1,1'b1,1'b0,4'd8}, // R8 single pulse
    '{2'd1,1'b1,1'b1,1'b1,6'd9 ,1'b1,1'b0,1'b0,4'd6}, // R6
    '{2'd1,1'b1,1'b1,1'b1,6'd8 ,1'b0,1'b0,1'b0,4'd5}, // R5 resume 8
    '{2'd1,1'b1,1'b1,1'b1,6'd20,1'b0,1'b1,1'b0,4'd6}, // R6
    '{2'd0,1'b1,1'b1,1'b1,6'd16,1'b1,1'b1,1'b1,4'd4}, // R4 pause 16
    '{2'd0,1'b1,1'b1,1'b1,6'd1 ,1'b1,1'b0,1'b0,4'd6}, // R6
    '{2'd0,1'b1,1'b1,1'b1,6'd0 ,1'b0,1'b0,1'b0,4'd5}, // R5 resume 0
    '{2'd3,1'b1,1'b1,1'b1,6'd27,1'b0,1'b0,1'b0,4'd3}, // R3 below 28
    '{2'd3,1'b1,1'b1,1'b1,6'd28,1'b1,1'b1,1'b1,4'd4}, // R4 pause 28
    '{2'd3,1'b1,1'b1,1'b1,6'd25,1'b1,1'b0,1'b0,4'd6}, // R6
    '{2'd3,1'b1,1'b1,1'b1,6'd24,1'b0,1'b0,1'b0,4'd5}, // R5 resume 24
    '{2'd2,1'b1,1'b1,1'b1,6'd24,1'b0,1'b1,1'b0,4'd3}, // R3 trig 24
    '{2'd2,1'b1,1'b1,1'b1,6'd32,1'b1,1'b1,1'b1,4'd4}, // R4 full
    '{2'd2,1'b1,1'b1,1'b1,6'd17,1'b1,1'b0,1'b0,4'd6}, // R6
    '{2'd2,1'b1,1'b1,1'b1,6'd16,1'b0,1'b0,1'b0,4'd5}, // R5 resume 16
    '{2'd2,1'b1,1'b0,1'b1,6'd0 ,1'b1,1'b0,1'b1,4'd7}, // R7 no sw
    '{2'd2,1'b1,1'b1,1'b0,6'd0 ,1'b0,1'b0,1'b0,4'd5}, // R5
    '{2'd2,1'b1,1'b1,1'b0,6'd32,1'b1,1'b1,1'b0,4'd9}  // R9 gated
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [1:0]       trig_sel = 2'd0;
  logic             auto_rts_en = 1'b0;
  logic             sw_rts = 1'b0;
  logic             rts_irq_en = 1'b0;
  logic             rts_n, trig_hit, rts_irq;
  int               total = 0;
  int               bad = 0;

  always #2 clk = ~clk;

  rx_rts_flow #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .rts_irq_en(rts_irq_en),
    .rts_n(rts_n), .trig_hit(trig_hit), .rts_irq(rts_irq)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(logic [1:0] s, logic a, logic w, logic ie, int l);
    @(negedge clk);
    trig_sel = s; auto_rts_en = a; sw_rts = w; rts_irq_en = ie;
    rx_level = LVL_W'(l);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state, in reset and just after
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rts_n in reset", rts_n, 1'b1);
    chk("R1", "irq in reset", rts_irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "rts_n after reset", rts_n, 1'b1);
    chk("R1", "hit after reset", trig_hit, 1'b0);

    foreach (VEC[i]) begin
      step(VEC[i].sel, VEC[i].aen, VEC[i].sw, VEC[i].ien, int'(VEC[i].lvl));
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d rts_n", i), rts_n, VEC[i].e_rts);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d hit", i), trig_hit, VEC[i].e_hit);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d irq", i), rts_irq, VEC[i].e_irq);
    end

    // R6 downward sweep through the band after a pause (row 01)
    step(2'd1, 1'b1, 1'b1, 1'b1, 8);
    step(2'd1, 1'b1, 1'b1, 1'b1, 24);
    chk("R4", "paused before sweep", rts_n, 1'b1);
    for (int l = 23; l >= 9; l--) begin
      step(2'd1, 1'b1, 1'b1, 1'b1, l);
      chk("R6", $sformatf("hold high at %0d", l), rts_n, 1'b1);
      chk("R8", $sformatf("no irq at %0d", l), rts_irq, 1'b0);
    end
    step(2'd1, 1'b1, 1'b1, 1'b1, 8);
    chk("R5", "resume after sweep", rts_n, 1'b0);
    // R6 upward sweep stays low
    for (int l = 9; l <= 23; l++) begin
      step(2'd1, 1'b1, 1'b1, 1'b1, l);
      chk("R6", $sformatf("hold low at %0d", l), rts_n, 1'b0);
    end

    // R2 manual mode ignores a full queue
    step(2'd0, 1'b0, 1'b1, 1'b1, 32);
    chk("R2", "manual asserted at full", rts_n, 1'b0);
    step(2'd0, 1'b0, 1'b0, 1'b1, 32);
    chk("R2", "manual release", rts_n, 1'b1);
    chk("R8", "irq on manual rise", rts_irq, 1'b1);

    // R1 reset mid-operation
    step(2'd0, 1'b0, 1'b1, 1'b1, 32);
    chk("R2", "asserted before reset", rts_n, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1", "rts_n on reset", rts_n, 1'b1);
    chk("R1", "hit on reset", trig_hit, 1'b0);
    chk("R1", "irq on reset", rts_irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule